// File: doc/BRIEF.md
# Daisy-Chain Bus Arbiter

This block settles ownership of one shared bus among a fixed number of masters. Each master has a small access cell. All cells feed one combined request line and one combined busy line back to a central controller. When the bus is free and some master is asking for it, the controller drives a single grant into the cell nearest to it. That grant then ripples along a serial chain. A cell that is requesting keeps the grant and becomes the owner. A cell that is not requesting hands the grant on to the next cell.

The owner holds the bus by raising the shared busy line until it signals that its transfer is done. The controller lowers its grant as soon as it sees busy. If the grant runs off the end of the chain with no taker, the controller withdraws it. Priority follows chain position: index 0 is nearest the controller and ranks highest. Everything runs on one clock. The asynchronous active-low reset is released through a synchronizer.

Top module: `daisy_arb_top`

## Requirements
- R1: While reset is applied, and after it is released with no requests, the owner vector, the shared busy line and the controller grant are all 0.
- R2: The shared request output is 1 exactly when at least one master that does not own the bus has its request input at 1.
- R3: When the controller grant is 0, busy is 0 and the shared request is 1 at a clock edge, the controller grant is 1 after that edge.
- R4: When several masters request at once, the owner bit that is set is the lowest-numbered requesting master. Bit i of every per-master vector belongs to master i, and master 0 is the head of the chain.
- R5: The winning master's owner bit and the shared busy line go to 1 at the clock edge after the edge that raised the controller grant.
- R6: A controller grant that is 1 while busy is 1 is 0 after the next clock edge.
- R7: When the owner's done input is 1 at an edge, its owner bit and the busy line are 0 after that edge.
- R8: At most one owner bit is ever set. Requests raised during a transfer do not change ownership; they win at the next arbitration after the bus is released.
- R9: A grant that passes every master untaken (no master requesting) is 0 after the next edge, and no owner bit is set.
- R10: A done input from a master that does not own the bus leaves the owner vector and busy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_MASTERS | Per-master bus request, bit i for master i |
| done_i | input | NUM_MASTERS | Per-master end-of-transfer strobe |
| owner_o | output | NUM_MASTERS | Per-master bus ownership |
| bus_req_o | output | 1 | Combined request line seen by the controller |
| bus_busy_o | output | 1 | Combined busy line |
| bus_grant_o | output | 1 | Grant driven by the controller into chain head |

## Verification
The bench builds the block with NUM_MASTERS = 4 and a two-stage reset synchronizer. Four cells give a head, a tail and two middle positions. That is enough to show a far master winning against an idle head, and a near master beating farther ones. With four cells the bench can also pass an unclaimed grant across every cell. The bench also raises a higher-priority request while a lower-priority master is mid-transfer, which exercises the deferred-request path.

// File: rtl/daisy_arb_pkg.sv
package daisy_arb_pkg;
  typedef enum logic [0:0] {
    CTRL_IDLE  = 1'b0,
    CTRL_GRANT = 1'b1
  } ctrl_state_e;
endpackage

// File: rtl/daisy_rst_sync.sv
module daisy_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n_i) begin
        if (!rst_n_i) sync_q <= '0;
        else          sync_q <= {sync_q[LAST-1:0], 1'b1};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n_i) begin
        if (!rst_n_i) sync_q <= '0;
        else          sync_q <= 1'b1;
      end
    end
  endgenerate

  assign rst_n_o = sync_q[LAST];
endmodule

// File: rtl/daisy_arb_ctrl.sv
module daisy_arb_ctrl
  import daisy_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bus_req_i,
  input  logic bus_busy_i,
  input  logic chain_tail_i,
  output logic grant_o
);
  ctrl_state_e state_q, state_d;
  logic        state_en;

  always_comb begin
    state_d = state_q;
    case (state_q)
      CTRL_IDLE: begin
        if (!bus_busy_i && bus_req_i) state_d = CTRL_GRANT;
      end
      CTRL_GRANT: begin
        // drop once a master holds the bus, or withdraw if the grant ran off the chain
        if (bus_busy_i || chain_tail_i) state_d = CTRL_IDLE;
      end
      default: state_d = CTRL_IDLE;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= CTRL_IDLE;
    else if (state_en) state_q <= state_d;
  end

  assign grant_o = (state_q == CTRL_GRANT);
endmodule

// File: rtl/daisy_arb_cell.sv
module daisy_arb_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic done_i,
  input  logic grant_in_i,
  input  logic bus_busy_i,
  output logic grant_out_o,
  output logic owner_o,
  output logic bus_req_o
);
  logic owner_q, owner_d, owner_en;
  logic take, release_bus;

  // a grant is only claimed while the bus is free
  assign take        = grant_in_i & req_i & ~owner_q & ~bus_busy_i;
  assign release_bus = owner_q & done_i;

  always_comb begin
    owner_d = owner_q;
    if (take)             owner_d = 1'b1;
    else if (release_bus) owner_d = 1'b0;
  end

  assign owner_en = take | release_bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        owner_q <= 1'b0;
    else if (owner_en) owner_q <= owner_d;
  end

  assign grant_out_o = grant_in_i & ~(req_i | owner_q);
  assign owner_o     = owner_q;
  assign bus_req_o   = req_i & ~owner_q;
endmodule

// File: rtl/daisy_arb_top.sv
module daisy_arb_top #(
  parameter int NUM_MASTERS = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req_i,
  input  logic [NUM_MASTERS-1:0] done_i,
  output logic [NUM_MASTERS-1:0] owner_o,
  output logic                   bus_req_o,
  output logic                   bus_busy_o,
  output logic                   bus_grant_o
);
  localparam int CHAIN_LEN = NUM_MASTERS + 1;

  logic                   rst_sync_n;
  logic [CHAIN_LEN-1:0]   chain;
  logic [NUM_MASTERS-1:0] cell_req;
  logic [NUM_MASTERS-1:0] cell_owner;
  logic                   ctrl_grant;

  daisy_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  daisy_arb_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .bus_req_i    (bus_req_o),
    .bus_busy_i   (bus_busy_o),
    .chain_tail_i (chain[NUM_MASTERS]),
    .grant_o      (ctrl_grant)
  );

  assign chain[0] = ctrl_grant;

  generate
    for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_cell
      daisy_arb_cell u_cell (
        .clk         (clk),
        .rst_n       (rst_sync_n),
        .req_i       (req_i[i]),
        .done_i      (done_i[i]),
        .grant_in_i  (chain[i]),
        .bus_busy_i  (bus_busy_o),
        .grant_out_o (chain[i+1]),
        .owner_o     (cell_owner[i]),
        .bus_req_o   (cell_req[i])
      );
    end
  endgenerate

  assign owner_o     = cell_owner;
  assign bus_req_o   = |cell_req;
  assign bus_busy_o  = |cell_owner;
  assign bus_grant_o = ctrl_grant;
endmodule

// File: rtl/daisy_arb_chk.sv
module daisy_arb_chk #(
  parameter int NUM_MASTERS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_MASTERS-1:0] req_i,
  input logic [NUM_MASTERS-1:0] done_i,
  input logic [NUM_MASTERS-1:0] owner_o,
  input logic                   bus_req_o,
  input logic                   bus_busy_o,
  input logic                   bus_grant_o
);
  a_r8_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(owner_o));

  a_r3_grant_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_grant_o && !bus_busy_o && bus_req_o) |=> bus_grant_o);

  a_r6_grant_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant_o && bus_busy_o) |=> !bus_grant_o);

  a_r9_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant_o && !bus_busy_o && (req_i == '0)) |=> (!bus_grant_o && (owner_o == '0)));

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy_o && ((done_i & owner_o) != '0)) |=> !bus_busy_o);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((owner_o != '0) && ((done_i & owner_o) == '0)) |=> $stable(owner_o));

  a_r4_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant_o && !bus_busy_o && (req_i != '0))
      |=> (owner_o == ($past(req_i) & (~$past(req_i) + 1'b1))));
endmodule

bind daisy_arb_top daisy_arb_chk #(.NUM_MASTERS(NUM_MASTERS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .req_i       (req_i),
  .done_i      (done_i),
  .owner_o     (owner_o),
  .bus_req_o   (bus_req_o),
  .bus_busy_o  (bus_busy_o),
  .bus_grant_o (bus_grant_o)
);

// File: tb/daisy_arb_top_test.sv
module daisy_arb_top_test;
  localparam int N = 4;
  localparam int NVEC = 6;
  // upper nibble: request mask, lower nibble: expected owner
  localparam logic [7:0] VEC [NVEC] = '{
    8'b0001_0001, 8'b1010_0010, 8'b1100_0100,
    8'b1111_0001, 8'b1000_1000, 8'b0110_0010
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req_i, done_i;
  logic [N-1:0] owner_o;
  logic         bus_req_o, bus_busy_o, bus_grant_o;
  int           checks = 0;
  int           fails = 0;
  bit           finished = 1'b0;

  always #4 clk = ~clk;

  daisy_arb_top #(.NUM_MASTERS(N), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .done_i(done_i),
    .owner_o(owner_o), .bus_req_o(bus_req_o),
    .bus_busy_o(bus_busy_o), .bus_grant_o(bus_grant_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_i = '0; done_i = '0;
    repeat (3) step();
    chk("R1 owner in reset", owner_o, 0);
    chk("R1 busy in reset", bus_busy_o, 0);
    chk("R1 grant in reset", bus_grant_o, 0);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R1 owner after reset", owner_o, 0);
    chk("R1 grant after reset", bus_grant_o, 0);

    for (int v = 0; v < NVEC; v++) begin
      logic [N-1:0] rq, ex;
      rq = VEC[v][7:4];
      ex = VEC[v][3:0];
      req_i = rq;
      #1 chk("R2 request line", bus_req_o, 1);
      step();
      chk("R3 grant issued", bus_grant_o, 1);
      chk("R5 no owner yet", owner_o, 0);
      step();
      chk("R4 winner", owner_o, ex);
      chk("R5 busy raised", bus_busy_o, 1);
      step();
      chk("R6 grant dropped", bus_grant_o, 0);
      req_i = '0; done_i = ex;
      step();
      chk("R7 owner released", owner_o, 0);
      chk("R7 busy released", bus_busy_o, 0);
      done_i = '0;
      step();
    end

    // R8: higher-priority request raised mid-transfer waits
    req_i = 4'b0100;
    step(); step();
    chk("R8 master 2 owns", owner_o, 4'b0100);
    req_i = 4'b0101;
    #1 chk("R2 request from non-owner", bus_req_o, 1);
    repeat (3) step();
    chk("R8 ownership unchanged", owner_o, 4'b0100);
    chk("R8 no new grant", bus_grant_o, 0);
    done_i = 4'b0100; req_i = 4'b0001;
    step();
    chk("R7 released before rearb", owner_o, 0);
    done_i = '0;
    step();
    chk("R8 rearb grant", bus_grant_o, 1);
    step();
    chk("R8 deferred request wins", owner_o, 4'b0001);

    // R10: done from a non-owner is ignored
    req_i = '0;
    done_i = 4'b1000;
    step();
    chk("R10 owner kept", owner_o, 4'b0001);
    chk("R10 busy kept", bus_busy_o, 1);
    done_i = 4'b0001;
    step();
    done_i = '0;
    chk("R7 final release", owner_o, 0);
    step();

    // R9: grant with no taker is withdrawn
    req_i = 4'b0010;
    step();
    chk("R9 grant issued", bus_grant_o, 1);
    req_i = '0;
    #1 chk("R2 request line low", bus_req_o, 0);
    step();
    chk("R9 grant withdrawn", bus_grant_o, 0);
    chk("R9 no owner", owner_o, 0);
    chk("R9 bus idle", bus_busy_o, 0);
    step();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule